// File: doc/BRIEF.md
# SDLC Frame Receiver with Station Address Filter

This block sits behind a bit-clock recovery stage. It takes one line bit on each cycle where `bitEn` is high and decodes the line as plain NRZ or as NRZI. It finds the 01111110 flag pattern, removes the zero that the sender inserts after five consecutive ones, and packs the remaining bits into bytes. The first bit received becomes bit 0 of each byte. The first byte of a frame is an address. A frame is passed on only when that address equals the programmed station address or the broadcast value FFh. Frames for any other station are dropped without any output.

Accepted frames come out one byte at a time on `outData` with `outValid`. `outFirst` marks the address byte and `outLast` marks the final byte before the check sequence. The two check-sequence bytes are never delivered. When a frame closes, a single-cycle status pulse reports one of four results: good, CRC error, abort, or too short. Two mode inputs change the expected frame layout. One removes the 16-bit check sequence, so the last byte before the closing flag is data. The other removes the control byte, which lowers the minimum legal frame length.

Top module: `sdlc_rx_filter`

## Requirements
- R1: With `nrziMode` low the line bit is the data bit. With it high, a line level equal to the previous sampled level decodes as 1 and a change decodes as 0. The remembered level is 1 after reset.
- R2: A decoded 0, six 1s, 0 sequence is a flag. It closes the open frame, if any, and opens a new one, so a single flag may end one frame and start the next. Flags with no whole byte between them produce no output and no status.
- R3: Inside a frame, a 0 that follows five consecutive data 1s is removed and not counted as data.
- R4: Bytes are assembled least significant bit first. A frame is accepted only if its first byte equals `stationAddr` or FFh. Any other frame produces no `outValid` and no status pulse.
- R5: Accepted bytes appear on `outData` with `outValid` for one clock, on the clock after the `bitEn` cycle that delivers them. `outFirst` is set with the address byte and `outLast` with the last non-FCS byte. The last non-FCS byte is output on the clock after the closing flag's final bit.
- R6: With `noFcsMode` low, the last two bytes of a frame are the FCS and are not output. The CRC uses polynomial x^16+x^12+x^5+1, processes data least significant bit first, and is preset to FFFFh. The frame is good when the residue over all bytes, FCS included, equals F0B8h. `frameGood` or `frameCrcErr` pulses together with `outLast`.
- R7: With `noFcsMode` high, no bytes are withheld, no check is made, and a closing frame of legal length reports `frameGood`.
- R8: The minimum frame length in whole bytes is 1 (address), plus 1 unless `noCtrlMode` is high (control), plus 2 unless `noFcsMode` is high (FCS).
- R9: An accepted frame shorter than the minimum length pulses `frameShort` when it closes. It then gives no `outLast`, no good or CRC-error pulse, and no data byte in that cycle.
- R10: Seven consecutive decoded 1s inside a frame abort it. Once the address has been accepted this pulses `frameAbort`. No bytes of the frame are delivered after the abort, and no frame starts again until a new flag arrives.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Line bit qualifier, one pulse per bit time |
| lineIn | input | 1 | Received line level |
| nrziMode | input | 1 | Decode NRZI instead of NRZ |
| noFcsMode | input | 1 | Frames carry no check sequence |
| noCtrlMode | input | 1 | Frames carry no control byte |
| stationAddr | input | 8 | Own station address |
| outData | output | 8 | Delivered frame byte |
| outValid | output | 1 | `outData` holds a byte this cycle |
| outFirst | output | 1 | Byte is the address byte |
| outLast | output | 1 | Byte is the final non-FCS byte |
| frameGood | output | 1 | Frame closed with a correct check (or none required) |
| frameCrcErr | output | 1 | Frame closed with a wrong check sequence |
| frameAbort | output | 1 | Accepted frame cut by seven ones |
| frameShort | output | 1 | Accepted frame closed below minimum length |

## Verification
The hardest cases to reach are where stuffing, flags and aborts interact with the byte hold-back. Examples are a data byte of FFh or 7Eh next to the closing flag, a frame whose only delivered byte is also its first and last, and a closing flag that also opens the next frame. The bench builds every frame from byte lists. It computes and inserts the check sequence, stuffs zeros as a sender would, and can corrupt the FCS, cut the frame with raw ones, or omit the opening flag. A behavioural model in the bench decodes the same line bits and predicts every output on every clock, in both line codings and all mode combinations.

// File: rtl/sdlc_rx_pkg.sv
`timescale 1ns/1ps
package sdlc_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET   = 16'hFFFF;

  // strobes from the line control to the byte datapath
  typedef struct packed {
    logic bitVal;    // decoded bit of this bit time
    logic dataBit;   // bitVal is payload inside an open frame
    logic flagSeen;  // flag completed on this bit
    logic abortSeen; // seventh one inside an open frame
  } rxStrobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] cIn,
                                               input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = cIn;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REV;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/sdlc_rx_ctrl.sv
`timescale 1ns/1ps
module sdlc_rx_ctrl
  import sdlc_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      lineIn,
  input  logic      nrziMode,
  output rxStrobe_t strobe
);
  logic       prevLine;
  logic [2:0] onesRun;
  logic       inFrame;
  logic       decBit;

  always_comb begin
    decBit           = nrziMode ? (lineIn == prevLine) : lineIn;
    strobe.bitVal    = decBit;
    strobe.dataBit   = bitEn && inFrame && (onesRun < 3'd5);
    strobe.flagSeen  = bitEn && !decBit && (onesRun == 3'd6);
    strobe.abortSeen = bitEn && decBit && (onesRun == 3'd6) && inFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine <= 1'b1;
      onesRun  <= '0;
      inFrame  <= 1'b0;
    end else if (bitEn) begin
      prevLine <= lineIn;
      if (decBit) onesRun <= (onesRun == 3'd7) ? onesRun : onesRun + 3'd1;
      else        onesRun <= '0;
      if (strobe.flagSeen)       inFrame <= 1'b1;
      else if (strobe.abortSeen) inFrame <= 1'b0;
    end
  end
endmodule

// File: rtl/sdlc_rx_dpath.sv
`timescale 1ns/1ps
module sdlc_rx_dpath
  import sdlc_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF,
  parameter logic [CRC_W-1:0]  CRC_GOOD   = 16'hF0B8,
  parameter int                CNT_W      = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              noFcsMode,
  input  logic              noCtrlMode,
  input  logic [BYTE_W-1:0] stationAddr,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic              frameGood,
  output logic              frameCrcErr,
  output logic              frameAbort,
  output logic              frameShort
);
  localparam int HOLD_N = 3;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BYTE_W-1:0]             shiftReg;
  logic [BIT_W-1:0]              bitCnt;
  logic [CNT_W-1:0]              byteCnt;
  logic [CRC_W-1:0]              crcReg;
  logic                          addrHit;
  logic [HOLD_N-1:0][BYTE_W-1:0] holdQ;

  logic [BYTE_W-1:0] newByte, oldest;
  logic [CNT_W-1:0]  depth, minLen;
  logic              byteDone, hitNow;

  always_comb begin
    newByte  = {strobe.bitVal, shiftReg[BYTE_W-1:1]};
    byteDone = strobe.dataBit && (bitCnt == BIT_W'(BYTE_W - 1));
    hitNow   = (newByte == stationAddr) || (newByte == BCAST_ADDR);
    depth    = noFcsMode ? CNT_W'(1) : CNT_W'(3);
    minLen   = CNT_W'(1 + (noCtrlMode ? 0 : 1) + (noFcsMode ? 0 : 2));
    oldest   = noFcsMode ? holdQ[0] : holdQ[HOLD_N-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0; bitCnt <= '0; byteCnt <= '0; crcReg <= CRC_PRESET;
      addrHit  <= 1'b0; holdQ <= '0; outData <= '0;
      outValid <= 1'b0; outFirst <= 1'b0; outLast <= 1'b0;
      frameGood <= 1'b0; frameCrcErr <= 1'b0; frameAbort <= 1'b0; frameShort <= 1'b0;
    end else begin
      outValid <= 1'b0; outFirst <= 1'b0; outLast <= 1'b0;
      frameGood <= 1'b0; frameCrcErr <= 1'b0; frameAbort <= 1'b0; frameShort <= 1'b0;
      if (strobe.flagSeen || strobe.abortSeen) begin
        if (byteCnt != '0 && addrHit) begin
          if (strobe.abortSeen) begin
            frameAbort <= 1'b1;
          end else if (byteCnt < minLen) begin
            frameShort <= 1'b1;
          end else begin
            outValid    <= 1'b1;
            outData     <= oldest;
            outLast     <= 1'b1;
            outFirst    <= (byteCnt == depth);
            frameGood   <= noFcsMode || (crcReg == CRC_GOOD);
            frameCrcErr <= !noFcsMode && (crcReg != CRC_GOOD);
          end
        end
        byteCnt <= '0; bitCnt <= '0; crcReg <= CRC_PRESET; addrHit <= 1'b0;
      end else if (strobe.dataBit) begin
        shiftReg <= newByte;
        bitCnt   <= bitCnt + 1'b1;
        if (byteDone) begin
          holdQ  <= {holdQ[HOLD_N-2:0], newByte};
          crcReg <= crcByte(crcReg, newByte);
          if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
          if (byteCnt == '0) addrHit <= hitNow;
          if (addrHit && byteCnt >= depth) begin
            outValid <= 1'b1;
            outData  <= oldest;
            outFirst <= (byteCnt == depth);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sdlc_rx_filter.sv
`timescale 1ns/1ps
module sdlc_rx_filter
  import sdlc_rx_pkg::*;
#(
  parameter logic [7:0]  BCAST_ADDR = 8'hFF,
  parameter logic [15:0] CRC_GOOD   = 16'hF0B8,
  parameter int          CNT_W      = 3
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       lineIn,
  input  logic       nrziMode,
  input  logic       noFcsMode,
  input  logic       noCtrlMode,
  input  logic [7:0] stationAddr,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outFirst,
  output logic       outLast,
  output logic       frameGood,
  output logic       frameCrcErr,
  output logic       frameAbort,
  output logic       frameShort
);
  rxStrobe_t strobe;

  sdlc_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .lineIn(lineIn),
    .nrziMode(nrziMode), .strobe(strobe)
  );

  sdlc_rx_dpath #(.BCAST_ADDR(BCAST_ADDR), .CRC_GOOD(CRC_GOOD), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .noFcsMode(noFcsMode), .noCtrlMode(noCtrlMode), .stationAddr(stationAddr),
    .outData(outData), .outValid(outValid), .outFirst(outFirst), .outLast(outLast),
    .frameGood(frameGood), .frameCrcErr(frameCrcErr),
    .frameAbort(frameAbort), .frameShort(frameShort)
  );
endmodule

// File: rtl/sdlc_rx_checker.sv
`timescale 1ns/1ps
module sdlc_rx_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic outValid,
  input logic outFirst,
  input logic outLast,
  input logic frameGood,
  input logic frameCrcErr,
  input logic frameAbort,
  input logic frameShort
);
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameGood, frameCrcErr, frameAbort, frameShort})); // R6
  AST_LAST_HAS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (frameGood || frameCrcErr)); // R6
  AST_GOOD_WITH_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (frameGood || frameCrcErr) |-> outLast); // R5
  AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outFirst || outLast) |-> outValid); // R5
  AST_SHORT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    frameShort |-> !outValid); // R9
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    frameAbort |-> !outValid); // R10
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameAbort |=> !frameAbort); // R10
  AST_OUT_AFTER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(bitEn)); // R5
endmodule

bind sdlc_rx_filter sdlc_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .outValid(outValid),
  .outFirst(outFirst), .outLast(outLast), .frameGood(frameGood),
  .frameCrcErr(frameCrcErr), .frameAbort(frameAbort), .frameShort(frameShort)
);

// File: tb/tb_sdlc_rx_filter.sv
`timescale 1ns/1ps
module tb_sdlc_rx_filter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, bitEn = 1'b0, lineIn = 1'b1;
  logic       nrziMode = 1'b0, noFcsMode = 1'b0, noCtrlMode = 1'b0;
  logic [7:0] stationAddr = 8'h5A;
  logic [7:0] outData;
  logic       outValid, outFirst, outLast, frameGood, frameCrcErr, frameAbort, frameShort;

  sdlc_rx_filter dut (.*);

  int    vecs = 0, bad = 0;
  string curReq = "R11";

  // expected outputs for the next compare
  logic [7:0] eData;
  logic eValid, eFirst, eLast, eGood, eCrc, eAbort, eShort;

  // behavioural receiver model
  int         mPrev = 1, mRun = 0, mBitN = 0, mAcc = 0;
  bit         mOpen = 0, mHit = 0;
  logic [7:0] mFrame[$];

  // transmitter state
  int txLevel = 1, txOnes = 0;

  task automatic clearExp();
    eData = 8'h00; eValid = 0; eFirst = 0; eLast = 0;
    eGood = 0; eCrc = 0; eAbort = 0; eShort = 0;
  endtask

  function automatic logic [15:0] fcsOf(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = ((c[0] ^ mFrame[i][k]) != 0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return ~c;
  endfunction

  task automatic modelReset();
    mFrame.delete(); mBitN = 0; mAcc = 0; mHit = 0;
  endtask

  task automatic modelByte(input logic [7:0] v);
    int n, h, idx;
    mFrame.push_back(v);
    n = mFrame.size();
    h = noFcsMode ? 1 : 3;
    if (n == 1) mHit = (v == stationAddr) || (v == 8'hFF);
    if (mHit && n > h) begin
      idx = n - 1 - h;
      eValid = 1; eData = mFrame[idx]; eFirst = (idx == 0);
    end
  endtask

  task automatic modelClose();
    int n, f, minL, idx;
    logic [15:0] fcs;
    n = mFrame.size();
    f = noFcsMode ? 0 : 2;
    minL = 1 + (noCtrlMode ? 0 : 1) + f;
    if (n > 0 && mHit) begin
      if (n < minL) eShort = 1;
      else begin
        idx = n - 1 - f;
        eValid = 1; eData = mFrame[idx]; eFirst = (idx == 0); eLast = 1;
        if (f == 0) eGood = 1;
        else begin
          fcs = fcsOf(n - 2);
          if (mFrame[n-2] == fcs[7:0] && mFrame[n-1] == fcs[15:8]) eGood = 1;
          else eCrc = 1;
        end
      end
    end
  endtask

  task automatic modelBit(input int lv);
    int d;
    d = nrziMode ? ((lv == mPrev) ? 1 : 0) : lv;
    mPrev = lv;
    if (d == 1) begin
      if (mRun == 6) begin
        if (mOpen && mFrame.size() > 0 && mHit) eAbort = 1;
        modelReset(); mOpen = 0;
      end else if (mRun < 5 && mOpen) begin
        mAcc = mAcc | (1 << mBitN); mBitN++;
      end
      if (mRun < 7) mRun++;
    end else begin
      if (mRun == 6) begin
        modelClose(); modelReset(); mOpen = 1;
      end else if (mRun < 5 && mOpen) begin
        mBitN++;
      end
      mRun = 0;
    end
    if (mBitN == 8) begin
      modelByte(mAcc[7:0]); mBitN = 0; mAcc = 0;
    end
  endtask

  // one clock: compare at the falling edge, then drive the next inputs
  task automatic stepCycle(input logic en, input int lv);
    @(negedge clk);
    vecs++;
    if ({outValid, outFirst, outLast, frameGood, frameCrcErr, frameAbort, frameShort} !==
        {eValid, eFirst, eLast, eGood, eCrc, eAbort, eShort} ||
        (eValid && outData !== eData)) begin
      bad++;
      $display("FAIL %s t=%0t actual v%b d%h f%b l%b g%b c%b a%b s%b expected v%b d%h f%b l%b g%b c%b a%b s%b",
               curReq, $time, outValid, outData, outFirst, outLast, frameGood, frameCrcErr,
               frameAbort, frameShort, eValid, eData, eFirst, eLast, eGood, eCrc, eAbort, eShort);
    end
    clearExp();
    bitEn  = en;
    lineIn = lv[0];
    if (en) modelBit(lv);
  endtask

  task automatic sendRaw(input int b);
    int lv;
    lv = nrziMode ? ((b == 1) ? txLevel : 1 - txLevel) : b;
    txLevel = lv;
    stepCycle(1, lv);
    stepCycle(0, lv);
  endtask

  task automatic sendFlag();
    sendRaw(0); repeat (6) sendRaw(1); sendRaw(0);
    txOnes = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      sendRaw(v[k]);
      if (v[k]) begin
        txOnes++;
        if (txOnes == 5) begin sendRaw(0); txOnes = 0; end
      end else txOnes = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) sendRaw(1);
  endtask

  // bytes already in mFrame-independent queue txQ
  logic [7:0] txQ[$];
  task automatic sendFrame(input bit withFcs, input bit corrupt, input bit openFlag);
    logic [15:0] c;
    c = 16'hFFFF;
    if (openFlag) sendFlag();
    foreach (txQ[i]) begin
      sendByte(txQ[i]);
      for (int k = 0; k < 8; k++)
        c = ((c[0] ^ txQ[i][k]) != 0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    if (withFcs) begin
      c = ~c;
      if (corrupt) c[3] = ~c[3];
      sendByte(c[7:0]); sendByte(c[15:8]);
    end
    sendFlag();
  endtask

  initial begin
    clearExp();
    repeat (4) stepCycle(0, 1);  // R11 reset state
    rstN = 1'b1;
    repeat (3) stepCycle(0, 1);

    // R2 R3 R5 R6: good frame with stuffing-heavy payload
    curReq = "R2 R3 R5 R6";
    idle(10);
    txQ = '{8'h5A, 8'h03, 8'hFF, 8'h7E, 8'h3E};
    sendFrame(1, 0, 1);
    // R2: shared flag closes and opens; empty flags stay silent
    curReq = "R2";
    txQ = '{8'h5A, 8'h13, 8'hF8};
    sendFrame(1, 0, 0);
    sendFlag(); sendFlag();
    idle(9);

    // R4: broadcast accepted, foreign address dropped
    curReq = "R4";
    txQ = '{8'hFF, 8'h10, 8'h81, 8'h1F};
    sendFrame(1, 0, 1);
    txQ = '{8'h5B, 8'h10, 8'h81, 8'h1F};
    sendFrame(1, 0, 1);
    txQ = '{8'h33, 8'h10};
    sendFrame(0, 0, 1);
    idle(9);

    // R6: corrupted check sequence
    curReq = "R6";
    txQ = '{8'h5A, 8'h44, 8'hC3, 8'h00};
    sendFrame(1, 1, 1);
    idle(9);

    // R10: abort mid-frame, then recovery only after a new flag
    curReq = "R10";
    sendFlag();
    sendByte(8'h5A); sendByte(8'h21); sendByte(8'h99); sendByte(8'hA5);
    repeat (9) sendRaw(1);
    sendByte(8'h00); sendByte(8'h5A);
    txQ = '{8'h5A, 8'h22, 8'h66};
    sendFrame(1, 0, 1);
    idle(9);

    // R9: frames below minimum length
    curReq = "R9";
    txQ = '{8'h5A, 8'h31};
    sendFrame(0, 0, 1);
    txQ = '{8'h5A, 8'h31, 8'h77};
    sendFrame(0, 0, 1);
    idle(9);

    // R7: no check sequence
    curReq = "R7";
    noFcsMode = 1'b1;
    txQ = '{8'h5A, 8'h22, 8'h44, 8'hFE};
    sendFrame(0, 0, 1);
    curReq = "R7 R9";
    txQ = '{8'h5A};
    sendFrame(0, 0, 1);
    idle(9);

    // R8: no control byte lowers the minimum
    curReq = "R8";
    noCtrlMode = 1'b1;
    txQ = '{8'hFF};
    sendFrame(0, 0, 1);
    noFcsMode = 1'b0;
    txQ = '{8'h5A};
    sendFrame(1, 0, 1);
    curReq = "R8 R9";
    txQ = '{8'h5A, 8'h7E};
    sendFrame(0, 0, 1);
    noCtrlMode = 1'b0;
    idle(9);

    // R1: NRZI line coding
    curReq = "R1";
    nrziMode = 1'b1;
    idle(10);
    txQ = '{8'h5A, 8'h0F, 8'hFF, 8'h00, 8'h7C};
    sendFrame(1, 0, 1);
    txQ = '{8'hFF, 8'h01, 8'h3F};
    sendFrame(1, 1, 0);
    idle(9);

    repeat (4) stepCycle(0, txLevel);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog %s actual=running expected=finished", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule